// File: doc/BRIEF.md
# Split-Lane Add/Subtract Unit

This block is a 48-bit adder/subtractor whose carry chain can be cut into independent lanes. With one setting it acts as a single 48-bit unit. The other settings split it into two 24-bit lanes or four 12-bit lanes. Each lane returns its own sum or difference, and reports its carry or borrow at a fixed bit of a shared 4-bit flag vector. The first operand comes in as two fields, an upper 30-bit part and a lower 18-bit part, and the unit joins them into one word. The second operand has its own 48-bit port.

One operation code sets every lane to add or to subtract at the same time. When subtracting, each lane computes the second operand minus the first. A tool that packs several small additions or subtractions into one unit can leave some lanes unused by tying their operands to zero. Those lanes then return zero for both the result and the flag. A parameter decides whether the outputs are registered. By default they are registered and update together on the rising clock edge.

Top module: `simd_lane_alu`

## Requirements
- R1: The first operand is `{opa_hi, opa_lo}`, with `opa_lo` in bits 17..0 and `opa_hi` in bits 47..18.
- R2: Lane mode 2'b00 gives one 48-bit lane, with its carry or borrow on `carry_vec[3]` and `carry_vec[2:0]` held at 0. The reserved mode 2'b11 behaves exactly like 2'b00.
- R3: Lane mode 2'b10 gives four 12-bit lanes. Lane k covers result bits 12k+11..12k. No carry or borrow passes from one lane into the next. `carry_vec[k]` holds the flag of lane k.
- R4: Lane mode 2'b01 gives two 24-bit lanes. The lower lane's flag is on `carry_vec[1]` and the upper lane's flag is on `carry_vec[3]`. `carry_vec[0]` and `carry_vec[2]` stay at 0.
- R5: Operation code 4'b0000 adds. So does every code other than 4'b0011. Each lane gives (opb + opa) modulo 2^lane width, and its flag is the carry out of the lane.
- R6: Operation code 4'b0011 subtracts in every lane. Each lane gives (opb − opa) modulo 2^lane width, and its flag is 1 exactly when the opb lane is smaller than the opa lane (a borrow).
- R7: A lane whose two operand slices are both zero gives a zero result and a zero flag, whether the unit adds or subtracts.
- R8: With REGISTERED=1, `result` and `carry_vec` take the value computed from the inputs present at a rising edge, one cycle after those inputs are applied. A synchronous active-high `rst` clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| opa_hi | input | 30 | Upper field of the first operand |
| opa_lo | input | 18 | Lower field of the first operand |
| opb | input | 48 | Second operand (minuend when subtracting) |
| lane_mode | input | 2 | 00 one lane, 01 two lanes, 10 four lanes, 11 same as 00 |
| alu_code | input | 4 | 0011 subtract, any other value add |
| result | output | 48 | Per-lane sums or differences |
| carry_vec | output | 4 | Per-lane carry (add) or borrow (subtract) flags |

## Verification
The lane cut and the subtract borrow can act in the same cycle. In the four-lane mode, subtraction inverts the first operand, so with all-ones or zero operands every segment produces a carry that a faulty cut would pass into its neighbour. The bench drives exactly these words in both codes and all lane modes, and judges each lane against a behavioural per-lane model every clock. A second overlap is reset arriving while live operands are present: the bench asserts `rst` with non-zero inputs and expects zeros on the next edge.

// File: rtl/simd_alu_pkg.sv
`timescale 1ns/1ps
package simd_alu_pkg;
    typedef enum logic [1:0] {
        LM_ONE48  = 2'b00,
        LM_TWO24  = 2'b01,
        LM_FOUR12 = 2'b10,
        LM_RSVD   = 2'b11
    } lane_mode_e;

    localparam logic [3:0] ALU_SUB = 4'b0011;
endpackage

// File: rtl/simd_lane_ctl.sv
`timescale 1ns/1ps
// Decodes the lane mode into segment masks: which segments open a lane
// and which close one.
module simd_lane_ctl
    import simd_alu_pkg::*;
#(
    parameter int SEGS = 4
) (
    input  logic [1:0]      lane_mode,
    output logic [SEGS-1:0] seg_start,
    output logic [SEGS-1:0] seg_end
);
    localparam int HALF = SEGS / 2;

    always_comb begin
        seg_start = '0;
        seg_end   = '0;
        unique case (lane_mode_e'(lane_mode))
            LM_FOUR12: begin
                seg_start = '1;
                seg_end   = '1;
            end
            LM_TWO24: begin
                for (int i = 0; i < SEGS; i++) begin
                    seg_start[i] = ((i % HALF) == 0);
                    seg_end[i]   = ((i % HALF) == HALF - 1);
                end
            end
            LM_ONE48, LM_RSVD: begin
                seg_start[0]      = 1'b1;
                seg_end[SEGS-1]   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/simd_seg_add.sv
`timescale 1ns/1ps
// One carry-chain segment: b + (a or ~a) + cin.
module simd_seg_add #(
    parameter int SW = 12
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          invert,
    input  logic          cin,
    output logic [SW-1:0] sum,
    output logic          cout
);
    logic [SW-1:0] a_eff;
    logic [SW:0]   total;

    always_comb begin
        a_eff = invert ? ~a : a;
        total = {1'b0, b} + {1'b0, a_eff} + {{SW{1'b0}}, cin};
        sum   = total[SW-1:0];
        cout  = total[SW];
    end
endmodule

// File: rtl/simd_out_reg.sv
`timescale 1ns/1ps
// Optional output stage with synchronous active-high reset.
module simd_out_reg #(
    parameter int W   = 52,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/simd_lane_alu.sv
`timescale 1ns/1ps
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int HI_W       = 30,
    parameter int LO_W       = 18,
    parameter int SEGS       = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HI_W-1:0]      opa_hi,
    input  logic [LO_W-1:0]      opa_lo,
    input  logic [HI_W+LO_W-1:0] opb,
    input  logic [1:0]           lane_mode,
    input  logic [3:0]           alu_code,
    output logic [HI_W+LO_W-1:0] result,
    output logic [SEGS-1:0]      carry_vec
);
    localparam int W  = HI_W + LO_W;
    localparam int SW = W / SEGS;

    logic [W-1:0]    opa;
    logic            sub;
    logic [SEGS-1:0] seg_start, seg_end, seg_cin, seg_cout, flag;
    logic [W-1:0]    sum_w;

    assign opa = {opa_hi, opa_lo};
    assign sub = (alu_code == ALU_SUB);

    simd_lane_ctl #(.SEGS(SEGS)) u_ctl (
        .lane_mode (lane_mode),
        .seg_start (seg_start),
        .seg_end   (seg_end)
    );

    generate
        for (genvar i = 0; i < SEGS; i++) begin : g_seg
            if (i == 0) begin : g_first
                assign seg_cin[i] = sub;
            end else begin : g_next
                assign seg_cin[i] = seg_start[i] ? sub : seg_cout[i-1];
            end

            simd_seg_add #(.SW(SW)) u_add (
                .a      (opa[i*SW +: SW]),
                .b      (opb[i*SW +: SW]),
                .invert (sub),
                .cin    (seg_cin[i]),
                .sum    (sum_w[i*SW +: SW]),
                .cout   (seg_cout[i])
            );

            // subtract: chain carry means "no borrow", flag reports borrow
            assign flag[i] = seg_end[i] & (seg_cout[i] ^ sub);
        end
    endgenerate

    simd_out_reg #(.W(W + SEGS), .REG(REGISTERED)) u_out (
        .clk (clk),
        .rst (rst),
        .d   ({flag, sum_w}),
        .q   ({carry_vec, result})
    );
endmodule

// File: rtl/simd_lane_alu_chk.sv
`timescale 1ns/1ps
module simd_lane_alu_chk #(
    parameter int HI_W       = 30,
    parameter int LO_W       = 18,
    parameter int SEGS       = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [HI_W-1:0]      opa_hi,
    input logic [LO_W-1:0]      opa_lo,
    input logic [HI_W+LO_W-1:0] opb,
    input logic [1:0]           lane_mode,
    input logic [3:0]           alu_code,
    input logic [HI_W+LO_W-1:0] result,
    input logic [SEGS-1:0]      carry_vec
);
    localparam int W  = HI_W + LO_W;
    localparam int SW = W / SEGS;

    generate
        if (REGISTERED) begin : g_props
            // R8
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (result == '0 && carry_vec == '0));

            // R2
            one_lane_flags_chk: assert property (@(posedge clk) disable iff (rst)
                (lane_mode == 2'b00 || lane_mode == 2'b11) |=> (carry_vec[SEGS-2:0] == '0));

            // R4
            two_lane_flags_chk: assert property (@(posedge clk) disable iff (rst)
                (lane_mode == 2'b01) |=> (carry_vec[0] == 1'b0 && carry_vec[2] == 1'b0));

            // R7
            zero_ops_chk: assert property (@(posedge clk) disable iff (rst)
                (opa_hi == '0 && opa_lo == '0 && opb == '0) |=> (result == '0 && carry_vec == '0));

            // R3
            lane0_add_chk: assert property (@(posedge clk) disable iff (rst)
                (lane_mode == 2'b10 && alu_code == 4'b0000) |=>
                ({carry_vec[0], result[SW-1:0]} ==
                 ({1'b0, $past(opb[SW-1:0])} + {1'b0, $past(opa_lo[SW-1:0])})));

            // R6
            lane1_sub_chk: assert property (@(posedge clk) disable iff (rst)
                (lane_mode == 2'b10 && alu_code == 4'b0011) |=>
                (result[2*SW-1:SW] == $past(opb[2*SW-1:SW]) - $past({opa_hi, opa_lo}[2*SW-1:SW])));
        end
    endgenerate
endmodule

bind simd_lane_alu simd_lane_alu_chk #(
    .HI_W(HI_W), .LO_W(LO_W), .SEGS(SEGS), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst(rst), .opa_hi(opa_hi), .opa_lo(opa_lo), .opb(opb),
    .lane_mode(lane_mode), .alu_code(alu_code),
    .result(result), .carry_vec(carry_vec)
);

// File: tb/sim_simd_lane_alu.sv
`timescale 1ns/1ps
module sim_simd_lane_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] opa_hi = '0;
    logic [17:0] opa_lo = '0;
    logic [47:0] opb = '0;
    logic [1:0]  lane_mode = '0;
    logic [3:0]  alu_code = '0;
    logic [47:0] result;
    logic [3:0]  carry_vec;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    simd_lane_alu u0 (
        .clk(clk), .rst(rst), .opa_hi(opa_hi), .opa_lo(opa_lo), .opb(opb),
        .lane_mode(lane_mode), .alu_code(alu_code),
        .result(result), .carry_vec(carry_vec)
    );

    // behavioural per-lane model: returns {flags, result}
    function automatic logic [51:0] model(input logic [47:0] a, input logic [47:0] b,
                                          input logic [1:0] m, input logic [3:0] c);
        int w;
        int n;
        longint unsigned mask, x, y, r, s, res;
        logic [3:0] fl;
        logic cy;
        w = (m == 2'b01) ? 24 : (m == 2'b10) ? 12 : 48;
        n = 48 / w;
        mask = (64'd1 << w) - 1;
        res = 0;
        fl = '0;
        for (int k = 0; k < n; k++) begin
            x = (longint'(a) >> (k * w)) & mask;
            y = (longint'(b) >> (k * w)) & mask;
            if (c == 4'b0011) begin
                r  = (y - x) & mask;
                cy = (y < x);
            end else begin
                s  = x + y;
                r  = s & mask;
                cy = ((s >> w) & 1) != 0;
            end
            res = res | (r << (k * w));
            if (w == 12)      fl[k] = cy;
            else if (w == 24) fl[2*k+1] = cy;
            else              fl[3] = cy;
        end
        return {fl, res[47:0]};
    endfunction

    task automatic check(input string tag, input logic [51:0] got, input logic [51:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic [3:0] c);
        string t;
        t = (m == 2'b10) ? "R3" : (m == 2'b01) ? "R4" : "R2";
        return {t, (c == 4'b0011) ? " R6" : " R5"};
    endfunction

    // drive, wait for the edge, sample 1 ns after it
    task automatic run(input string tag, input logic [29:0] hi, input logic [17:0] lo,
                       input logic [47:0] b, input logic [1:0] m, input logic [3:0] c);
        opa_hi = hi; opa_lo = lo; opb = b; lane_mode = m; alu_code = c;
        @(posedge clk);
        #1;
        check(tag, {carry_vec, result}, model({hi, lo}, b, m, c));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [51:0] prev;
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset state", {carry_vec, result}, 52'd0);
        rst = 1'b0;

        // R1: field placement
        run("R1 low field", 30'd0, 18'h3FFFF, 48'd0, 2'b00, 4'b0000);
        check("R1 low value", {carry_vec, result}, {4'd0, 48'h0000_0003_FFFF});
        run("R1 high field", 30'd1, 18'd0, 48'd0, 2'b00, 4'b0000);
        check("R1 high value", {carry_vec, result}, {4'd0, 48'h0000_0004_0000});

        // all-ones: carry cut at every lane boundary, both codes, all modes
        for (int m = 0; m < 4; m++) begin
            run(tag_of(m[1:0], 4'b0000), '1, '1, '1, m[1:0], 4'b0000);
            run(tag_of(m[1:0], 4'b0011), '1, '1, '0, m[1:0], 4'b0011);
            run(tag_of(m[1:0], 4'b0011), '0, '0, '1, m[1:0], 4'b0011);
            run(tag_of(m[1:0], 4'b0011), '1, '1, '1, m[1:0], 4'b0011);
        end
        run("R3 R5 four-lane all ones", '1, '1, '1, 2'b10, 4'b0000);
        check("R3 per-lane carries", {carry_vec, result}, {4'hF, 48'hFFE_FFE_FFE_FFE});
        run("R4 R6 two-lane borrow", '0, 18'd1, 48'd0, 2'b01, 4'b0011);
        check("R4 lower borrow only", {carry_vec, result}, {4'b0010, 48'h000000_FFFFFF});
        run("R2 reserved mode", 30'd0, 18'd1, '1, 2'b11, 4'b0000);
        check("R2 reserved wraps to one lane", {carry_vec, result}, {4'b1000, 48'd0});
        run("R5 other code adds", 30'd0, 18'd5, 48'd7, 2'b10, 4'b0101);
        check("R5 code 0101 sum", {carry_vec, result}, {4'd0, 48'd12});

        // R7: partly filled units, upper lanes tied to zero
        run("R7 zero lanes sub", 30'd0, 18'h00ABC, 48'h0000_0012_3456, 2'b10, 4'b0011);
        check("R7 upper lanes zero", {carry_vec[3:2], result[47:24]}, 26'd0);
        run("R7 zero lanes add", 30'd0, 18'h00FFF, 48'h0000_0000_0FFF, 2'b10, 4'b0000);
        check("R7 upper lanes zero add", {carry_vec[3:1], result[47:24]}, 27'd0);
        run("R7 all zero sub", '0, '0, '0, 2'b00, 4'b0011);

        // R8: output holds until the edge
        prev = {carry_vec, result};
        opa_hi = 30'h1234; opa_lo = 18'h5678; opb = 48'h9; lane_mode = 2'b00; alu_code = 4'b0000;
        #1;
        check("R8 holds before edge", {carry_vec, result}, prev);
        @(posedge clk);
        #1;
        check("R8 updates after edge", {carry_vec, result}, model({opa_hi, opa_lo}, opb, 2'b00, 4'b0000));

        // random vectors across modes and codes
        for (int i = 0; i < 600; i++) begin
            logic [1:0] m;
            logic [3:0] c;
            m = 2'($urandom);
            c = ($urandom % 2 == 0) ? 4'b0011 : 4'b0000;
            run(tag_of(m, c), 30'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)}, m, c);
        end

        // R8: reset with live operands
        opa_hi = '1; opa_lo = '1; opb = '1; lane_mode = 2'b10; alu_code = 4'b0000;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 reset with live inputs", {carry_vec, result}, 52'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R8 resume after reset", {carry_vec, result}, model('1, '1, 2'b10, 4'b0000));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule